// File: doc/BRIEF.md
# Serial Flash Fast-Read Responder

This block is the device side of a single-bit serial flash bus, and it serves only the fast-read command. A host lowers chip select and sends the 8-bit opcode 0Bh. It then sends a 24-bit start address and one dummy byte. After that the block streams bytes from an internal synchronous memory port. The address steps by one after each byte and wraps over the whole array, so one command can read without end. Raising chip select ends the command at any point.

The block runs on a system clock that is faster than the serial clock. It finds serial-clock edges by comparing each sample of the pin with the one before. The host must hold chip select low for at least two system clocks before the first serial-clock rise. The block refuses the command in two cases: when the program/erase logic reports busy at the moment the opcode completes, and when the opcode is unknown. A refused command leaves the output disabled and issues no memory reads until chip select rises.

The state machine has six states:
- `ST_IDLE`: chip select is high.
- `ST_CMD`: receiving the opcode.
- `ST_ADDR`: receiving the address.
- `ST_DUMMY`: skipping the dummy byte.
- `ST_DATA`: streaming bytes.
- `ST_IGNORE`: a refused command waits for release.

Its transitions are:
- `T_SEL`: IDLE to CMD when chip select is low.
- `T_OPOK`: CMD to ADDR on the 8th rise when the opcode matches and busy is low.
- `T_REJ`: CMD to IGNORE on the 8th rise otherwise.
- `T_ADONE`: ADDR to DUMMY on the 24th rise.
- `T_DDONE`: DUMMY to DATA on the 8th rise.
- `T_REL`: any state to IDLE when chip select is high.

Top module: `fastrd_responder`

## Requirements
- R1: After reset, and while chip select is high, `spi_miso_oe` is low and no memory read is issued.
- R2: All host bits are sampled on serial-clock rising edges, MSB first, starting with the 8-bit opcode; only 0Bh starts a read.
- R3: The 24-bit address follows the opcode, MSB first (bit 23 first). Only its low `ADDR_W` bits are kept.
- R4: `spi_miso_oe` stays low through the opcode, address and dummy phases. The first data bit is driven on the serial-clock fall that follows the 40th rising edge.
- R5: Data bits leave MSB first and change only on serial-clock falling edges. The first byte is the memory content at the received address.
- R6: After each byte starts shifting, the address increments by one. The next byte is fetched with a single-cycle `mem_rd_en` pulse well before its MSB is due. The memory port returns data one clock after the read.
- R7: After address 2^ADDR_W-1 the address wraps to 0, and streaming continues with no limit.
- R8: Chip select going high at any point, in any phase, returns the block to idle. `spi_miso_oe` is then low on the next clock.
- R9: An opcode other than 0Bh makes the block ignore the rest of the transaction: no output enable and no memory reads.
- R10: If `wr_busy` is high when the opcode completes, the command is refused: no output enable and no memory reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from host |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` (low = high impedance) |
| wr_busy | input | 1 | Program/erase/write cycle in progress |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid one clock after `mem_rd_en` |

## Verification
The bench builds the block with `ADDR_W` = 6, a 64-byte array. This puts the top of the array within a few bytes of a start address. It also means a 24-bit address with high bits set is masked down to a low location. One run of 70 bytes wraps past the top more than once. The serial clock runs at eight system clocks per period, which is slow enough for the one-clock memory latency. A behavioural model predicts the enable and the data bit on every system clock. It also counts the memory reads expected in each transaction, including the aborted and refused ones.

// File: rtl/fastrd_pkg.sv
package fastrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } fr_state_e;

    localparam logic [7:0] FR_OPCODE     = 8'h0B;
    localparam int         FR_CMD_BITS   = 8;
    localparam int         FR_ADDR_BITS  = 24;
    localparam int         FR_DUMMY_BITS = 8;

endpackage

// File: rtl/fastrd_edge_det.sv
module fastrd_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;

endmodule

// File: rtl/fastrd_tx_ser.sv
module fastrd_tx_ser (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load,
    input  logic       shift,
    input  logic       fill,
    input  logic [7:0] rdata,
    output logic       bit_out
);
    logic [7:0] nxt_buf;
    logic [6:0] out_sr;
    logic       bit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_buf <= '0;
            out_sr  <= '0;
            bit_q   <= 1'b0;
        end else begin
            if (fill) nxt_buf <= rdata;
            if (clear) begin
                out_sr <= '0;
                bit_q  <= 1'b0;
            end else if (load) begin
                bit_q  <= nxt_buf[7];
                out_sr <= nxt_buf[6:0];
            end else if (shift) begin
                bit_q  <= out_sr[6];
                out_sr <= {out_sr[5:0], 1'b0};
            end
        end
    end

    assign bit_out = bit_q;

endmodule

// File: rtl/fastrd_responder.sv
module fastrd_responder
    import fastrd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              wr_busy,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    localparam int CNT_W = $clog2(FR_ADDR_BITS + 1);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(FR_CMD_BITS - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(FR_ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(FR_DUMMY_BITS - 1);

    fr_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [6:0]        op_sr;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        bit_idx_q;
    logic              rd_en_q, rd_vld_q, oe_q;
    logic              sck_rise, sck_fall, ser_bit;
    logic              ld_byte, sh_bit;

    fastrd_edge_det u_sck_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig  (spi_sck),
        .rise (sck_rise),
        .fall (sck_fall)
    );

    assign ld_byte = (state_q == ST_DATA) && sck_fall && !spi_cs_n && (bit_idx_q == 3'd0);
    assign sh_bit  = (state_q == ST_DATA) && sck_fall && !spi_cs_n && (bit_idx_q != 3'd0);

    fastrd_tx_ser u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (spi_cs_n),
        .load   (ld_byte),
        .shift  (sh_bit),
        .fill   (rd_vld_q),
        .rdata  (mem_rdata),
        .bit_out(ser_bit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (spi_cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_CMD;
                ST_CMD:   if (sck_rise && cnt_q == CMD_LAST)
                              state_d = ({op_sr, spi_mosi} == FR_OPCODE && !wr_busy)
                                        ? ST_ADDR : ST_IGNORE;
                ST_ADDR:  if (sck_rise && cnt_q == ADDR_LAST)  state_d = ST_DUMMY;
                ST_DUMMY: if (sck_rise && cnt_q == DUMMY_LAST) state_d = ST_DATA;
                ST_DATA:  state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            op_sr     <= '0;
            addr_q    <= '0;
            bit_idx_q <= '0;
            rd_en_q   <= 1'b0;
            rd_vld_q  <= 1'b0;
            oe_q      <= 1'b0;
        end else begin
            rd_en_q  <= 1'b0;
            rd_vld_q <= rd_en_q;
            if (spi_cs_n) begin
                cnt_q     <= '0;
                bit_idx_q <= '0;
                oe_q      <= 1'b0;
            end else begin
                if (sck_rise && state_q inside {ST_CMD, ST_ADDR, ST_DUMMY})
                    cnt_q <= (state_d != state_q) ? '0 : cnt_q + CNT_W'(1);
                if (state_q == ST_CMD && sck_rise)
                    op_sr <= {op_sr[5:0], spi_mosi};
                if (state_q == ST_ADDR && sck_rise) begin
                    addr_q <= {addr_q[ADDR_W-2:0], spi_mosi};
                    if (cnt_q == ADDR_LAST) rd_en_q <= 1'b1;
                end
                if (state_q == ST_DATA && sck_fall) begin
                    oe_q      <= 1'b1;
                    bit_idx_q <= bit_idx_q + 3'd1;
                    if (bit_idx_q == 3'd0) begin
                        addr_q  <= addr_q + ADDR_W'(1);
                        rd_en_q <= 1'b1;
                    end
                end
            end
        end
    end

    // outputs
    always_comb begin
        spi_miso    = ser_bit;
        spi_miso_oe = oe_q;
        mem_rd_en   = rd_en_q;
        mem_addr    = addr_q;
    end

    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |=> (state_q == ST_IDLE && !spi_miso_oe)); // R8
    AST_OE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n) spi_miso_oe |-> (state_q == ST_DATA)); // R4
    AST_IGNORE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IGNORE) |-> !mem_rd_en); // R9
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) mem_rd_en |=> !mem_rd_en); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) ld_byte |=> (addr_q == $past(addr_q) + ADDR_W'(1))); // R7
    AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (spi_miso_oe && !sck_fall && !spi_cs_n) |=> $stable(spi_miso)); // R5

endmodule

// File: tb/fastrd_responder_tb.sv
module fastrd_responder_tb;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_sck = 1'b0;
    logic          spi_mosi = 1'b0;
    logic          spi_miso, spi_miso_oe;
    logic          wr_busy = 1'b0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = 8'h00;
    logic [7:0]    mem [DEPTH];

    int    checks = 0;
    int    fails = 0;
    int    rd_count = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    logic  exp_oe = 1'b0;
    logic  exp_bit = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    fastrd_responder #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .wr_busy(wr_busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 29 + 7) ^ (i << 3));
    end

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_count  <= rd_count + 1;
        end
    end

    // per-clock comparison against the behavioural expectation
    always @(posedge clk) begin
        #1;
        if (chk_on) begin
            checks++;
            if (spi_miso_oe !== exp_oe) begin
                fails++;
                $display("FAIL %s: miso_oe=%b expected %b at %0t", cur_req, spi_miso_oe, exp_oe, $time);
            end else if (exp_oe && spi_miso !== exp_bit) begin
                fails++;
                $display("FAIL %s: miso=%b expected %b at %0t", cur_req, spi_miso, exp_bit, $time);
            end
        end
    end

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic xfer(input logic [7:0] op, input logic [23:0] a, input int total_bits,
                        input bit accept, input string req);
        logic [39:0] frame;
        int          d, reads_before, exp_reads, nf;
        frame = {op, a, 8'h00};
        cur_req = req;
        reads_before = rd_count;
        @(negedge clk);
        spi_cs_n = 1'b0;
        exp_oe   = 1'b0;
        repeat (3) @(negedge clk);
        for (int j = 0; j < total_bits; j++) begin
            spi_mosi = (j < 40) ? frame[39 - j] : 1'b0;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
            if (accept && j >= 39) begin
                d       = j - 39;
                exp_oe  = 1'b1;
                exp_bit = mem[(int'(a[AW-1:0]) + d / 8) % DEPTH][7 - (d % 8)];
            end
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        exp_oe   = 1'b0;
        repeat (4) @(negedge clk);
        nf = total_bits - 39;
        exp_reads = (accept && total_bits >= 32) ? 1 + ((nf > 0) ? (nf + 7) / 8 : 0) : 0;
        check_int({req, " read count"}, rd_count - reads_before, exp_reads);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 oe after reset", int'(spi_miso_oe), 0);
        check_int("R1 rd_en after reset", int'(mem_rd_en), 0);
        chk_on = 1'b1;
        repeat (4) @(negedge clk);

        xfer(8'h0B, 24'h000010, 40 + 24, 1'b1, "R2/R4/R5 basic");
        xfer(8'h0B, 24'hABCD7E, 40 + 32, 1'b1, "R3/R7 masked wrap");
        xfer(8'h0B, 24'h00003C, 40 + 8 * 70, 1'b1, "R7 unlimited stream");
        xfer(8'h0B, 24'h000005, 40 + 13, 1'b1, "R8 release mid-data");
        wr_busy = 1'b1;
        xfer(8'h0B, 24'h000008, 40 + 16, 1'b0, "R10 busy refusal");
        wr_busy = 1'b0;
        xfer(8'h03, 24'h000008, 40 + 16, 1'b0, "R9 wrong opcode");
        xfer(8'h0B, 24'h000011, 20, 1'b1, "R8 release in address");
        xfer(8'h0B, 24'h000020, 40 + 16, 1'b1, "R6 increment after aborts");

        check_int("R1 oe idle at end", int'(spi_miso_oe), 0);
        finish_run();
    end

    initial begin
        #(4 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

endmodule